// File: doc/BRIEF.md
# Delayed Interrupt Blanking Writer

This block sits between a host and the bus of a peripheral interface adapter whose countdown timer sets how long the beam of a vector display moves. The host arms the block before a draw. When the timer interrupt arrives, the block waits a programmed number of peripheral clock cycles. It then issues, with no host involvement, the bus write that drives the active-low beam blanking output. Blanking therefore follows the release of the ramp signal, and a visible line ends where the beam comes to rest.

The block reaches the peripheral bus once per peripheral clock, marked by a one-cycle enable. In each of those slots it presents either its own blanking write or the host request waiting there. The interrupt input is asynchronous. It passes through a synchroniser and an edge detector, so only a fresh rising edge starts the sequence. The delay is counted in peripheral slots, never in system clocks. The blanking write is also held back for as long as the ramp input reports that the beam is still moving.

Top module: `autoblank_writer`

## Requirements
- R1: During and right after reset, `bus_valid`, `bus_auto`, `host_ack`, `armed` and `done` are all 0.
- R2: A one-clock `arm_i` pulse while disarmed makes `armed` read 1 from the next clock. If `disarm_i` is high in the same clock, it wins and `armed` stays 0.
- R3: The trigger is a rising edge of `irq_async`, seen after a two-stage synchroniser. A level held high does not trigger again, and edges that arrive while disarmed are ignored.
- R4: With `delay_i` = N > 0, the block counts N peripheral slots (clocks where `pclk_en` = 1) after the detection edge. It issues the blanking write in the slot after those N. If the input rises at edge T0, detection happens at edge T0+2.
- R5: With `delay_i` = 0, the blanking write goes out in the first peripheral slot after the detection edge.
- R6: No blanking write is issued while `ramp_n` = 0. Once `ramp_n` returns to 1, the write goes out in the first peripheral slot that samples `ramp_n` high.
- R7: The blanking write is a single-clock bus cycle: `bus_valid` = 1, `bus_we` = 1, `bus_addr` = BLANK_ADDR (default 4'hA), `bus_wdata` = BLANK_DATA (default 8'h80), `bus_auto` = 1.
- R8: The block fires at most once per arming. `armed` drops to 0 in the same clock that the write appears.
- R9: The blanking write wins its slot over a pending host request. That request gets no `host_ack` and is served in the next peripheral slot.
- R10: A host request present in a peripheral slot is issued as a one-clock bus cycle carrying the host's we, address and data. `host_ack` is 1 in that same clock and `bus_auto` is 0.
- R11: `done` rises in the clock of the blanking write and is cleared when the block is next armed.
- R12: A `disarm_i` pulse while armed, counting or pending cancels the sequence. No blanking write follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pclk_en | input | 1 | One-clock strobe marking each peripheral bus slot |
| irq_async | input | 1 | Timer interrupt (flag or enabled IRQ line), asynchronous |
| ramp_n | input | 1 | Active-low ramp; 0 while the beam is moving |
| arm_i | input | 1 | Arm pulse from host |
| disarm_i | input | 1 | Disarm/cancel pulse from host |
| delay_i | input | DLY_W | Post-interrupt delay in peripheral slots |
| host_req | input | 1 | Host bus request, held until acknowledged |
| host_we | input | 1 | Host write enable |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | DATA_W | Host write data |
| host_ack | output | 1 | Host request issued this clock |
| bus_valid | output | 1 | Bus cycle presented this clock |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | ADDR_W | Bus register address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_auto | output | 1 | Bus cycle is the automatic blanking write |
| armed | output | 1 | Block armed or sequence in progress |
| done | output | 1 | Blanking write completed since last arm |

## Verification
The bench measures the exact edge of each blanking write against the interrupt edge, at every phase of the peripheral strobe and for delays of 0, 1, 3, 5, 12 and 15. An off-by-one in the counter or an extra synchroniser stage would show up as a latency shifted by one slot or one clock. It holds the interrupt high across a re-arm, where a level-sensitive trigger would blank at once. It keeps the ramp low past the delay, where a design without the gate would blank a moving beam. It lines a host request up with the blanking slot, where a wrong priority would let the host through first or drop the request. Disarm in mid-count and a simultaneous arm/disarm are also covered. A design that ignores either would still blank, or would be left armed.

// File: rtl/abw_pkg.sv
package abw_pkg;

    // Sequencer states of the blanking writer
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // disarmed
        ST_ARMED = 2'd1,   // waiting for interrupt edge
        ST_DELAY = 2'd2,   // counting peripheral slots
        ST_PEND  = 2'd3    // write due at next eligible slot
    } abw_state_e;

endpackage

// File: rtl/abw_edge_sync.sv
module abw_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_s;

    sync_s sync_d, sync_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb begin
                sync_d.chain = {sync_q.chain[STAGES-2:0], async_i};
                sync_d.last  = sync_q.chain[STAGES-1];
            end
        end else begin : g_single
            always_comb begin
                sync_d.chain = async_i;
                sync_d.last  = sync_q.chain[0];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise_o = sync_q.chain[STAGES-1] & ~sync_q.last;

endmodule

// File: rtl/abw_ctrl.sv
module abw_ctrl
    import abw_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_i,
    input  logic             rise_i,
    input  logic             ramp_n_i,
    input  logic             arm_i,
    input  logic             disarm_i,
    input  logic [DLY_W-1:0] delay_i,
    output logic             fire_o,
    output logic             armed_o,
    output logic             done_o
);

    localparam logic [DLY_W-1:0] CNT_ONE = DLY_W'(1);

    typedef struct packed {
        abw_state_e       st;
        logic [DLY_W-1:0] cnt;
        logic             done;
    } ctrl_s;

    ctrl_s ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        fire_o = 1'b0;
        if (disarm_i) begin
            ctrl_d.st = ST_IDLE;
        end else begin
            unique case (ctrl_q.st)
                ST_IDLE: begin
                    if (arm_i) begin
                        ctrl_d.st   = ST_ARMED;
                        ctrl_d.done = 1'b0;
                    end
                end
                ST_ARMED: begin
                    if (rise_i) begin
                        ctrl_d.cnt = delay_i;
                        ctrl_d.st  = (delay_i == '0) ? ST_PEND : ST_DELAY;
                    end
                end
                ST_DELAY: begin
                    if (ce_i) begin
                        if (ctrl_q.cnt == CNT_ONE) ctrl_d.st = ST_PEND;
                        ctrl_d.cnt = ctrl_q.cnt - CNT_ONE;
                    end
                end
                ST_PEND: begin
                    if (ce_i && ramp_n_i) begin
                        fire_o      = 1'b1;
                        ctrl_d.st   = ST_IDLE;
                        ctrl_d.done = 1'b1;
                    end
                end
                default: ctrl_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.st   <= ST_IDLE;
            ctrl_q.cnt  <= '0;
            ctrl_q.done <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign armed_o = (ctrl_q.st != ST_IDLE);
    assign done_o  = ctrl_q.done;

endmodule

// File: rtl/abw_bus_mux.sv
module abw_bus_mux #(
    parameter int                ADDR_W     = 4,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] BLANK_ADDR = '0,
    parameter logic [DATA_W-1:0] BLANK_DATA = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_i,
    input  logic              fire_i,
    input  logic              host_req_i,
    input  logic              host_we_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic              host_ack_o,
    output logic              valid_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              auto_o
);

    typedef struct packed {
        logic              valid;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              auto_wr;
        logic              ack;
    } bus_s;

    bus_s bus_d, bus_q;

    always_comb begin
        bus_d = '0;
        if (fire_i) begin
            bus_d.valid   = 1'b1;
            bus_d.we      = 1'b1;
            bus_d.addr    = BLANK_ADDR;
            bus_d.wdata   = BLANK_DATA;
            bus_d.auto_wr = 1'b1;
        end else if (ce_i && host_req_i) begin
            bus_d.valid = 1'b1;
            bus_d.we    = host_we_i;
            bus_d.addr  = host_addr_i;
            bus_d.wdata = host_wdata_i;
            bus_d.ack   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    assign valid_o    = bus_q.valid;
    assign we_o       = bus_q.we;
    assign addr_o     = bus_q.addr;
    assign wdata_o    = bus_q.wdata;
    assign auto_o     = bus_q.auto_wr;
    assign host_ack_o = bus_q.ack;

endmodule

// File: rtl/autoblank_writer.sv
module autoblank_writer #(
    parameter int                DLY_W       = 8,
    parameter int                ADDR_W      = 4,
    parameter int                DATA_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] BLANK_ADDR  = 4'hA,
    parameter logic [DATA_W-1:0] BLANK_DATA  = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pclk_en,
    input  logic              irq_async,
    input  logic              ramp_n,
    input  logic              arm_i,
    input  logic              disarm_i,
    input  logic [DLY_W-1:0]  delay_i,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic              bus_valid,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_auto,
    output logic              armed,
    output logic              done
);

    logic irq_rise;
    logic fire;

    abw_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_async),
        .rise_o  (irq_rise)
    );

    abw_ctrl #(
        .DLY_W (DLY_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_i     (pclk_en),
        .rise_i   (irq_rise),
        .ramp_n_i (ramp_n),
        .arm_i    (arm_i),
        .disarm_i (disarm_i),
        .delay_i  (delay_i),
        .fire_o   (fire),
        .armed_o  (armed),
        .done_o   (done)
    );

    abw_bus_mux #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .BLANK_ADDR (BLANK_ADDR),
        .BLANK_DATA (BLANK_DATA)
    ) u_mux (
        .clk          (clk),
        .rst_n        (rst_n),
        .ce_i         (pclk_en),
        .fire_i       (fire),
        .host_req_i   (host_req),
        .host_we_i    (host_we),
        .host_addr_i  (host_addr),
        .host_wdata_i (host_wdata),
        .host_ack_o   (host_ack),
        .valid_o      (bus_valid),
        .we_o         (bus_we),
        .addr_o       (bus_addr),
        .wdata_o      (bus_wdata),
        .auto_o       (bus_auto)
    );

endmodule

// File: rtl/abw_checker.sv
module abw_checker #(
    parameter int                ADDR_W     = 4,
    parameter logic [ADDR_W-1:0] BLANK_ADDR = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pclk_en,
    input logic              ramp_n,
    input logic              host_ack,
    input logic              bus_valid,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_auto,
    input logic              armed,
    input logic              done
);

    // R10
    slot_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> $past(pclk_en));

    // R6
    ramp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_auto |-> $past(ramp_n));

    // R7
    blank_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_auto |-> (bus_valid && bus_we && bus_addr == BLANK_ADDR));

    // R8
    single_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_auto |-> !armed);

    // R11
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> bus_auto);

    // R11
    arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> !done);

    // R9
    host_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> (bus_valid && !bus_auto));

    // R9
    owner_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({host_ack, bus_auto}));

endmodule

bind autoblank_writer abw_checker #(
    .ADDR_W     (ADDR_W),
    .BLANK_ADDR (BLANK_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pclk_en   (pclk_en),
    .ramp_n    (ramp_n),
    .host_ack  (host_ack),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_auto  (bus_auto),
    .armed     (armed),
    .done      (done)
);

// File: tb/tb_autoblank_writer.sv
module tb_autoblank_writer;

    localparam int          DLY_W = 8;
    localparam int          ADDR_W = 4;
    localparam int          DATA_W = 8;
    localparam logic [3:0]  BADDR = 4'hA;
    localparam logic [7:0]  BDATA = 8'h80;

    // {delay, strobe phase of interrupt edge, expected latency in clocks}
    localparam logic [23:0] VECS [6] = '{
        {8'd0,  8'd0, 8'd4},
        {8'd1,  8'd1, 8'd7},
        {8'd3,  8'd2, 8'd18},
        {8'd12, 8'd3, 8'd53},
        {8'd15, 8'd0, 8'd64},
        {8'd5,  8'd1, 8'd23}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              pclk_en = 1'b0;
    logic              irq_async = 1'b0;
    logic              ramp_n = 1'b1;
    logic              arm_i = 1'b0;
    logic              disarm_i = 1'b0;
    logic [DLY_W-1:0]  delay_i = '0;
    logic              host_req = 1'b0;
    logic              host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic              host_ack, bus_valid, bus_we, bus_auto, armed, done;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;

    int t = 0;
    int total = 0;
    int bad = 0;
    int wd = 0;

    autoblank_writer dut (
        .clk(clk), .rst_n(rst_n), .pclk_en(pclk_en), .irq_async(irq_async),
        .ramp_n(ramp_n), .arm_i(arm_i), .disarm_i(disarm_i), .delay_i(delay_i),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ack(host_ack), .bus_valid(bus_valid),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_auto(bus_auto), .armed(armed), .done(done)
    );

    always @(posedge clk) begin
        wd = wd + 1;
        if (wd > 100000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // After step returns, outputs reflect edge t-1; inputs set now hit edge t.
    task automatic step;
        @(negedge clk);
        t = t + 1;
        pclk_en = (t % 4 == 0);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic arm_pulse;
        step;
        arm_i = 1'b1;
        step;
        arm_i = 1'b0;
    endtask

    task automatic raise_irq(input int p, output int t0);
        do step; while (t % 4 != p);
        irq_async = 1'b1;
        t0 = t;
    endtask

    task automatic wait_auto(input int maxw, output int tf);
        tf = -1;
        for (int i = 0; i < maxw && tf < 0; i++) begin
            step;
            if (bus_valid && bus_auto) tf = t - 1;
        end
    endtask

    task automatic wait_ack(input int maxw, output int ta);
        ta = -1;
        for (int i = 0; i < maxw && ta < 0; i++) begin
            step;
            if (host_ack) ta = t - 1;
        end
    endtask

    initial begin
        int t0, tf, tr, ta;
        // reset
        repeat (5) step;
        chk("R1 bus_valid", bus_valid, 0);
        chk("R1 host_ack", host_ack, 0);
        chk("R1 armed", armed, 0);
        chk("R1 done", done, 0);
        rst_n = 1'b1;
        step;
        chk("R1 bus_auto after release", bus_auto, 0);

        // vector table: delay / phase / latency
        for (int i = 0; i < 6; i++) begin
            delay_i = VECS[i][23:16];
            irq_async = 1'b0;
            repeat (4) step;
            arm_pulse;
            chk("R2 armed after arm", armed, 1);
            chk("R11 done cleared by arm", done, 0);
            raise_irq(int'(VECS[i][15:8]), t0);
            wait_auto(400, tf);
            if (VECS[i][23:16] == 8'd0)
                chk("R5 zero-delay latency", tf - t0, int'(VECS[i][7:0]));
            else
                chk("R4 delay latency", tf - t0, int'(VECS[i][7:0]));
            chk("R7 we", bus_we, 1);
            chk("R7 addr", bus_addr, BADDR);
            chk("R7 data", bus_wdata, BDATA);
            chk("R11 done set", done, 1);
            chk("R8 disarmed after fire", armed, 0);
            step;
            chk("R7 single clock", bus_valid, 0);
            irq_async = 1'b0;
        end

        // R8 / R3: new edge after firing, without re-arm, is ignored
        repeat (4) step;
        irq_async = 1'b1;
        wait_auto(60, tf);
        chk("R8 no second fire", tf, -1);
        chk("R3 edge ignored while disarmed, done kept", done, 1);

        // R3: level already high at arm does not trigger
        delay_i = 8'd2;
        arm_pulse;
        wait_auto(80, tf);
        chk("R3 held level no retrigger", tf, -1);
        chk("R3 still armed", armed, 1);
        irq_async = 1'b0;
        repeat (4) step;
        raise_irq(0, t0);
        wait_auto(200, tf);
        chk("R3 fresh edge fires", tf - t0, 12);
        irq_async = 1'b0;

        // R12: disarm mid-count
        delay_i = 8'd10;
        repeat (4) step;
        arm_pulse;
        raise_irq(2, t0);
        repeat (8) step;
        disarm_i = 1'b1;
        step;
        disarm_i = 1'b0;
        wait_auto(100, tf);
        chk("R12 cancel no write", tf, -1);
        chk("R12 disarmed", armed, 0);
        irq_async = 1'b0;

        // R2: arm and disarm together
        repeat (4) step;
        step;
        arm_i = 1'b1;
        disarm_i = 1'b1;
        step;
        arm_i = 1'b0;
        disarm_i = 1'b0;
        chk("R2 disarm wins", armed, 0);

        // R6: ramp still asserted past the delay
        delay_i = 8'd0;
        ramp_n = 1'b0;
        arm_pulse;
        raise_irq(0, t0);
        wait_auto(40, tf);
        chk("R6 held while ramp low", tf, -1);
        do step; while (t % 4 != 2);
        ramp_n = 1'b1;
        tr = t;
        wait_auto(40, tf);
        chk("R6 write after ramp release", tf - tr, 2);
        irq_async = 1'b0;

        // R10: host pass-through
        repeat (4) step;
        do step; while (t % 4 != 1);
        host_req = 1'b1;
        host_we = 1'b1;
        host_addr = 4'h3;
        host_wdata = 8'h55;
        t0 = t;
        wait_ack(20, ta);
        chk("R10 host slot", ta - t0, 3);
        chk("R10 addr", bus_addr, 4'h3);
        chk("R10 data", bus_wdata, 8'h55);
        chk("R10 not auto", bus_auto, 0);
        host_req = 1'b0;

        // R9: host request colliding with the blanking slot
        repeat (4) step;
        delay_i = 8'd0;
        arm_pulse;
        raise_irq(1, t0);
        host_req = 1'b1;
        host_we = 1'b0;
        host_addr = 4'h6;
        wait_auto(20, tf);
        chk("R9 auto wins slot", tf - t0, 3);
        chk("R9 host stalled", host_ack, 0);
        wait_ack(20, ta);
        chk("R9 host served next slot", ta - tf, 4);
        chk("R9 host addr", bus_addr, 4'h6);
        host_req = 1'b0;
        irq_async = 1'b0;
        repeat (4) step;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule